// File: doc/BRIEF.md
# Machine Cycle and Clock-Out Control

This block holds one byte-wide control register for a small 8-bit core. The register sets two things. The first is how many oscillator clocks make up one machine cycle, from one to eight. The second is what the shared port pin carries: ordinary GPIO, the oscillator itself, or the oscillator divided by two or by four.

From the first setting the block produces a single-clock machine-cycle enable strobe. The core uses this strobe to advance its state. From the second setting the block drives the pin's clock value, together with an ownership flag. The port multiplexer uses that flag to hand the pin over from GPIO.

Software may rewrite either field at any moment while the core runs. A new cycle length is applied only at the next machine-cycle boundary, so no strobe period is ever cut short. The dividers run freely from reset and are built as registers, never as gated clocks.

Top module: `mcyc_clkctl`

## Requirements
- R1: After a synchronous reset the register reads 8'h10: the cycle-length code is 3'b001 and the pin field is 2'b00.
- R2: The cycle-length code is written from and read back at bits [6:4].
- R3: Bits 7, 3 and 2 ignore writes and always read as 0. For example, writing 8'hFF reads back 8'h73.
- R4: For a code N in 1 to 7, the strobe is high for exactly one clock and then low for N clocks, giving a period of N+1 clocks.
- R5: With code 3'b000 the strobe is high on every clock.
- R6: A new code written in the middle of a machine cycle does not change that cycle. The current period ends at its old length, and the following period uses the new length.
- R7: The pin field is written from and read back at bits [1:0]. When it is 2'b00, the clock output is held low and the ownership flag is low.
- R8: When the pin field is 2'b01, the clock output follows the oscillator clock: high while the clock is high and low while it is low.
- R9: When the pin field is 2'b10, the clock output is a registered divide-by-2 that toggles on every rising clock edge.
- R10: When the pin field is 2'b11, the clock output is a registered divide-by-4 with 50% duty: two clocks high, then two clocks low.
- R11: The ownership flag is high whenever the pin field is not 2'b00.
- R12: After reset, with no write, the strobe period is two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable, one clock per write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| mc_stb | output | 1 | Machine-cycle enable strobe |
| pin_clk | output | 1 | Clock value for the shared pin |
| pin_own | output | 1 | High when the clock output owns the pin |

## Verification
The hardest case to reach is a cycle-length change that lands in the middle of a machine cycle. Only the timing of later strobes shows whether the old period was honoured. The bench first locks onto a strobe with the longest code in force. It then writes a short code exactly three clocks into that period. Finally it measures the next two strobe intervals, expecting the old length and then the new one.

// File: rtl/mcc_pkg.sv
// Package of shared types and defaults for the machine-cycle and clock-out control block.
// Assumes an 8-bit register with fixed field positions that the core's software decodes.
package mcc_pkg;
    localparam int REG_W   = 8;
    localparam int TIM_W   = 3;
    localparam int TIM_LSB = 4;
    localparam int SEL_W   = 2;
    localparam int SEL_LSB = 0;
    localparam int DIV_W   = 2;
    localparam logic [TIM_W-1:0] TIM_RST = 3'd1;

    typedef enum logic [SEL_W-1:0] {
        CKO_GPIO  = 2'b00,
        CKO_FULL  = 2'b01,
        CKO_HALF  = 2'b10,
        CKO_QUART = 2'b11
    } cko_sel_e;
endpackage

// File: rtl/mcc_cfg_reg.sv
// Control register: keeps the cycle-length code and the pin-select field.
// Bits outside both fields are not stored and read back as zero.
// Assumes one write per asserted clock and no read strobe (the read is combinational).
module mcc_cfg_reg #(
    parameter int RW = 8,
    parameter int TW = 3,
    parameter int TL = 4,
    parameter int SW = 2,
    parameter int SL = 0,
    parameter logic [TW-1:0] TRST = 3'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wdata,
    output logic [TW-1:0] tim_o,
    output logic [SW-1:0] sel_o,
    output logic [RW-1:0] rdata
);
    // Register the two fields on a write; synchronous reset to the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_o <= TRST;
            sel_o <= '0;
        end else if (we) begin
            tim_o <= wdata[TL +: TW];
            sel_o <= wdata[SL +: SW];
        end
    end

    // Assemble the read value; bits that are not stored stay at zero.
    always_comb begin
        rdata = '0;
        rdata[TL +: TW] = tim_o;
        rdata[SL +: SW] = sel_o;
    end
endmodule

// File: rtl/mcc_cyc_strobe.sv
// Machine-cycle strobe generator. The strobe marks the last clock of each machine cycle.
// The active length is taken from the register only on a strobe clock, so a change
// never shortens or stretches the period already in progress.
module mcc_cyc_strobe #(
    parameter int TW = 3,
    parameter logic [TW-1:0] TRST = 3'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tim_i,
    output logic          stb
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] act;

    // A boundary is reached when the counter meets the active length.
    assign stb = (cnt == act);

    // Count clocks within a cycle and load the new length at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= TRST;
        end else if (stb) begin
            cnt <= '0;
            act <= tim_i;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mcc_clk_out.sv
// Pin clock source: a free-running registered divider chain and an output selector.
// The full-rate choice passes the oscillator through the selector. The divided choices
// come from flops, so no gated clock is created.
module mcc_clk_out
    import mcc_pkg::*;
#(
    parameter int DW = 2,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel_i,
    output logic          pin_clk,
    output logic          pin_own
);
    logic [DW-1:0] div_q;

    // Ripple-free binary count; bit k is the clock divided by 2^(k+1).
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Choose the pin value from the select field.
    always_comb begin
        case (sel_i)
            CKO_FULL:  pin_clk = clk;
            CKO_HALF:  pin_clk = div_q[0];
            CKO_QUART: pin_clk = div_q[DW-1];
            default:   pin_clk = 1'b0;
        endcase
    end

    // Any choice other than GPIO claims the pin.
    assign pin_own = (sel_i != CKO_GPIO);
endmodule

// File: rtl/mcyc_clkctl.sv
// Top of the machine-cycle and clock-out control block: the register, the strobe
// generator and the pin clock source. Assumes clk is the free-running oscillator.
module mcyc_clkctl
    import mcc_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int TW = TIM_W,
    parameter int TL = TIM_LSB,
    parameter int SW = SEL_W,
    parameter int SL = SEL_LSB,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    output logic          mc_stb,
    output logic          pin_clk,
    output logic          pin_own
);
    logic [TW-1:0] tim_q;
    logic [SW-1:0] sel_q;

    mcc_cfg_reg #(.RW(RW), .TW(TW), .TL(TL), .SW(SW), .SL(SL), .TRST(TIM_RST)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .tim_o(tim_q), .sel_o(sel_q), .rdata(cfg_rdata)
    );

    mcc_cyc_strobe #(.TW(TW), .TRST(TIM_RST)) u_stb (
        .clk(clk), .rst_n(rst_n), .tim_i(tim_q), .stb(mc_stb)
    );

    mcc_clk_out #(.DW(DW), .SW(SW)) u_cko (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_q), .pin_clk(pin_clk), .pin_own(pin_own)
    );
endmodule

// File: rtl/mcyc_clkctl_chk.sv
// Checker of port-level properties for mcyc_clkctl, attached through bind.
module mcyc_clkctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       mc_stb,
    input logic       pin_clk,
    input logic       pin_own
);
    // Reset value appears on the clock after reset is sampled low.
    assert_reset_value_R1: assert property (@(posedge clk) !rst_n |=> (cfg_rdata == 8'h10));

    // Unused bits always read zero.
    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & 8'h8C) == 8'h00);

    // With a nonzero code, a strobe is followed by at least one low clock.
    assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_stb && cfg_rdata[6:4] != 3'd0) |=> !mc_stb);

    // With code zero at a boundary, the strobe stays high on the next clock.
    assert_strobe_solid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_stb && cfg_rdata[6:4] == 3'd0) |=> mc_stb);

    // The divide-by-2 output toggles every clock while that mode is held.
    assert_half_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b10 && $past(cfg_rdata[1:0]) == 2'b10) |-> (pin_clk != $past(pin_clk)));

    // The ownership flag tracks the pin field.
    assert_owner_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_own == (cfg_rdata[1:0] != 2'b00));
endmodule

bind mcyc_clkctl mcyc_clkctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
    .mc_stb(mc_stb), .pin_clk(pin_clk), .pin_own(pin_own)
);

// File: tb/mcyc_clkctl_test.sv
// Bench for mcyc_clkctl: a vector table walk, then directed reset and corner tests.
module mcyc_clkctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       mc_stb, pin_clk, pin_own;
    int         errs = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    mcyc_clkctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mc_stb(mc_stb), .pin_clk(pin_clk), .pin_own(pin_own)
    );

    // {write data, expected read, expected period, expected ownership}
    localparam logic [23:0] VEC [0:7] = '{
        {8'h00, 8'h00, 4'd1, 4'd0},
        {8'h10, 8'h10, 4'd2, 4'd0},
        {8'h21, 8'h21, 4'd3, 4'd1},
        {8'h32, 8'h32, 4'd4, 4'd1},
        {8'h43, 8'h43, 4'd5, 4'd1},
        {8'hD0, 8'h50, 4'd6, 4'd0},
        {8'h6C, 8'h60, 4'd7, 4'd0},
        {8'hFF, 8'h73, 4'd8, 4'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Advance to the next negedge at which the strobe is high.
    task automatic find_stb();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (mc_stb) return;
        end
    endtask

    // Clocks from the current strobe to the next one.
    task automatic gap(output int n);
        n = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            n++;
            if (mc_stb) return;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value, R7 pin idle
        chk("R1 reset read", cfg_rdata, 8'h10);
        chk("R7 pin low after reset", pin_clk, 0);
        chk("R11 own low after reset", pin_own, 0);
        // R12 default period
        find_stb();
        gap(n);
        chk("R12 default period", n, 2);

        // Table walk: R2 R3 R4 R5 R11
        foreach (VEC[k]) begin
            wr(VEC[k][23:16]);
            chk("R2/R3 readback", cfg_rdata, VEC[k][15:8]);
            chk("R11 ownership", pin_own, VEC[k][3:0]);
            find_stb();
            gap(n);
            chk((VEC[k][7:4] == 1) ? "R5 solid strobe" : "R4 period", n, VEC[k][7:4]);
        end

        // R6: change from code 7 to code 2 three clocks into a period
        wr(8'h70);
        find_stb();
        gap(n);
        find_stb();
        n = 0;
        for (int i = 1; i <= 32; i++) begin
            @(negedge clk);
            cfg_we = (i == 3);
            cfg_wdata = 8'h20;
            n++;
            if (mc_stb) break;
        end
        cfg_we = 1'b0;
        chk("R6 old period kept", n, 8);
        gap(n);
        chk("R6 new period", n, 3);

        // R8 full-rate pin clock follows oscillator
        wr(8'h01);
        @(posedge clk); #1;
        chk("R8 pin high phase", pin_clk, 1);
        @(negedge clk); #1;
        chk("R8 pin low phase", pin_clk, 0);

        // R9 divide-by-2
        wr(8'h02);
        for (int i = 0; i < 8; i++) begin @(negedge clk); s[i] = pin_clk; end
        for (int i = 0; i < 7; i++) chk("R9 half toggles", s[i] ^ s[i+1], 1);

        // R10 divide-by-4
        wr(8'h03);
        for (int i = 0; i < 8; i++) begin @(negedge clk); s[i] = pin_clk; end
        chk("R10 quarter duty", $countones(s), 4);
        for (int i = 0; i < 6; i++) chk("R10 quarter period", s[i] ^ s[i+2], 1);

        // R7 GPIO mode
        wr(8'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 pin low in GPIO", pin_clk, 0);
            chk("R7 own low in GPIO", pin_own, 0);
        end

        // R1 reset again after changes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reread after reset", cfg_rdata, 8'h10);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule